// File: doc/BRIEF.md
# Systematic Polar Encoder

This block turns a K-bit message into an N-bit polar codeword in which every message bit can be read back unchanged at a fixed set of codeword positions, the information positions. The remaining positions are frozen. The encoder works by transforming twice over GF(2) with the generator G, the n-fold Kronecker power of the 2x2 kernel [[1,0],[1,1]] with N = 2^n. The message is first placed on the information positions, with zeros elsewhere, and multiplied by G. The frozen positions of that result are then cleared, and the vector is multiplied by G again. Because G is its own inverse, the final codeword re-encodes to a vector that is zero on every frozen position.

Two configurations are supported through the parameter `N`. With N = 8 it is an (8,5) code with frozen positions {0,1,2}. With N = 16 it is a (16,11) code with frozen positions {0,1,2,4,8}. The transform logic is combinational. A single output register captures the codeword whenever the input strobe is high.

Top module: `polar_sys_enc`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and cw_o is all zeros.
- R2: valid_o equals valid_i as sampled on the previous rising clock edge. The codeword therefore appears one cycle after the strobe.
- R3: Message bit k (data_i[k]) appears unchanged at cw_o[p]. Here p is the k-th information position counted upward from bit 0. For N=16 these positions are 3,5,6,7,9..15, and for N=8 they are 3..7.
- R4: Re-encoding a produced codeword gives y with y_i = XOR of cw_o[j] over all j whose bit set contains i. That y is zero at every frozen position: {0,1,2,4,8} for N=16 and {0,1,2} for N=8.
- R5: cw_o is exactly the unique N-bit vector that satisfies both R3 and R4 for the captured message.
- R6: While valid_i is low, cw_o holds its last value and data_i has no effect.
- R7: With N=8 the block accepts 5 message bits and produces 8-bit codewords that meet R3 to R5.
- R8: An all-zero message encodes to an all-zero codeword.
- R9: A new message can be accepted on every cycle, and each codeword matches its own message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Message strobe |
| data_i | input | K | Message bits (K = 11 for N=16, K = 5 for N=8) |
| valid_o | output | 1 | Codeword strobe |
| cw_o | output | N | Systematic codeword |

## Verification
The tests use an all-zero message, an all-ones message, a walk of a single set bit across every message position, and a long back-to-back pseudo-random sequence. The single-bit walk shows whether each message bit is routed to the correct information position and whether its parity reaches the frozen-position constraints. The all-ones message exercises every XOR path at once. The random stream shows whether consecutive codewords stay separate from one another. The expected codeword comes from a brute-force search over the frozen-position values, which is independent of the two-pass transform. A held-strobe test changes data_i while valid_i is low, to show that the output register keeps its value.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;
  localparam int MAX_N = 16;
  typedef logic [MAX_N-1:0] word_t;

  function automatic word_t frozen_mask(int n);
    if (n == 8) return 16'h0007;
    return 16'h0117;
  endfunction

  function automatic int num_info(int n);
    word_t m;
    int c;
    m = frozen_mask(n);
    c = 0;
    for (int i = 0; i < MAX_N; i++) if (i < n && !m[i]) c++;
    return c;
  endfunction

  // number of information positions below p
  function automatic int info_rank(word_t m, int p);
    int r;
    r = 0;
    for (int i = 0; i < MAX_N; i++) if (i < p && !m[i]) r++;
    return r;
  endfunction

  // y = x * G, used only by assertions
  function automatic word_t kron_mul(word_t x, int n);
    word_t y;
    y = x;
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < MAX_N; j++)
        if (((j >> s) & 1) == 0 && (j + (1 << s)) < n)
          y[j] = y[j] ^ y[j + (1 << s)];
    return y;
  endfunction

  function automatic word_t gather_info(word_t cw, word_t m, int n);
    word_t r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < MAX_N; i++)
      if (i < n && !m[i]) begin
        r[k] = cw[i];
        k++;
      end
    return r;
  endfunction
endpackage

// File: rtl/polar_scatter.sv
module polar_scatter
  import polar_enc_pkg::*;
#(
  parameter int    N      = 16,
  parameter int    K      = 11,
  parameter word_t FROZEN = 16'h0117
) (
  input  logic [K-1:0] data_i,
  output logic [N-1:0] vec_o
);
  for (genvar p = 0; p < N; p++) begin : g_pos
    if (FROZEN[p]) begin : g_frz
      assign vec_o[p] = 1'b0;
    end else begin : g_inf
      localparam int RANK = info_rank(FROZEN, p);
      assign vec_o[p] = data_i[RANK];
    end
  end
endmodule

// File: rtl/polar_xform.sv
module polar_xform #(
  parameter int N = 16,
  localparam int LOG = $clog2(N)
) (
  input  logic [N-1:0] a_i,
  output logic [N-1:0] y_o
);
  logic [N-1:0] lvl [LOG+1];

  assign lvl[0] = a_i;

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    localparam int STRIDE = 1 << s;
    for (genvar j = 0; j < N; j++) begin : g_bit
      if (((j >> s) & 1) == 0) begin : g_xor
        assign lvl[s+1][j] = lvl[s][j] ^ lvl[s][j+STRIDE];
      end else begin : g_pass
        assign lvl[s+1][j] = lvl[s][j];
      end
    end
  end

  assign y_o = lvl[LOG];
endmodule

// File: rtl/polar_sys_enc.sv
module polar_sys_enc
  import polar_enc_pkg::*;
#(
  parameter int N = 16,
  localparam int K = num_info(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [K-1:0] data_i,
  output logic         valid_o,
  output logic [N-1:0] cw_o
);
  localparam word_t FROZEN_W = frozen_mask(N);
  localparam logic [N-1:0] FROZEN = FROZEN_W[N-1:0];

  logic [N-1:0] v_place, w_mid, u_clr, x_cw;

  polar_scatter #(.N(N), .K(K), .FROZEN(FROZEN_W)) u_scatter (
    .data_i (data_i),
    .vec_o  (v_place)
  );

  polar_xform #(.N(N)) u_pass1 (.a_i(v_place), .y_o(w_mid));

  assign u_clr = w_mid & ~FROZEN;

  polar_xform #(.N(N)) u_pass2 (.a_i(u_clr), .y_o(x_cw));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cw_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) cw_o <= x_cw;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && cw_o == '0));

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r3_info_intact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (gather_info(word_t'(cw_o), FROZEN_W, N)
                 == word_t'($past(data_i))));

  a_r4_frozen_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((kron_mul(word_t'(cw_o), N) & FROZEN_W) == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cw_o));
endmodule

// File: tb/polar_sys_enc_bench.sv
`timescale 1ns/1ps
module polar_sys_enc_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [10:0] d16 = '0;
  logic [4:0]  d8  = '0;
  logic        vo16, vo8;
  logic [15:0] cw16;
  logic [7:0]  cw8;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  polar_sys_enc #(.N(16)) u_polar_sys_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(d16),
    .valid_o(vo16), .cw_o(cw16));

  polar_sys_enc #(.N(8)) u_polar_sys_enc_n8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(d8),
    .valid_o(vo8), .cw_o(cw8));

  function automatic logic [15:0] fmask(int n);
    return (n == 8) ? 16'h0007 : 16'h0117;
  endfunction

  // re-encode: y_i = XOR of x_j over supersets j of i
  function automatic logic [15:0] reenc(logic [15:0] x, int n);
    logic [15:0] y = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if ((i & j) == i) y[i] = y[i] ^ x[j];
    return y;
  endfunction

  function automatic logic [15:0] info_of(logic [15:0] x, int n);
    logic [15:0] r = '0;
    int k = 0;
    logic [15:0] m = fmask(n);
    for (int i = 0; i < n; i++)
      if (!m[i]) begin r[k] = x[i]; k++; end
    return r;
  endfunction

  // brute-force search over frozen-position values
  function automatic logic [15:0] ref_enc(logic [15:0] data, int n);
    logic [15:0] m = fmask(n);
    int nf = (n == 8) ? 3 : 5;
    for (int f = 0; f < (1 << nf); f++) begin
      logic [15:0] x = '0;
      int k = 0;
      int fi = 0;
      for (int i = 0; i < n; i++) begin
        if (m[i]) begin x[i] = f[fi]; fi++; end
        else begin x[i] = data[k]; k++; end
      end
      if ((reenc(x, n) & m) == '0) return x;
    end
    return 16'hDEAD;
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R3, R4, R5 on N=16 and R7 on N=8 for a captured message
  task automatic check_cw(logic [10:0] data, string tag);
    logic [15:0] e16 = ref_enc({5'b0, data}, 16);
    logic [15:0] e8  = ref_enc({11'b0, data[4:0]}, 8);
    chk(info_of(cw16, 16) == {5'b0, data}, {"R3 ", tag}, info_of(cw16, 16), {5'b0, data});
    chk((reenc(cw16, 16) & 16'h0117) == '0, {"R4 ", tag}, reenc(cw16, 16) & 16'h0117, 16'h0);
    chk(cw16 == e16, {"R5 ", tag}, cw16, e16);
    chk({8'b0, cw8} == e8 && (reenc({8'b0, cw8}, 8) & 16'h0007) == '0,
        {"R7 ", tag}, {8'b0, cw8}, e8);
  endtask

  task automatic send(logic [10:0] data);
    @(negedge clk_i);
    valid_i = 1'b1; d16 = data; d8 = data[4:0];
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(vo16 && vo8, "R2 strobe", {14'b0, vo16, vo8}, 16'h3);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!vo16 && !vo8, "R1 valid", {14'b0, vo16, vo8}, 16'h0);
    chk(cw16 == '0 && cw8 == '0, "R1 cw", cw16 | {8'b0, cw8}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_zero;
    send(11'h7FF);
    send(11'h000);
    chk(cw16 == '0 && cw8 == '0, "R8 zero", cw16 | {8'b0, cw8}, 16'h0);
  endtask

  task automatic t_ones;
    send(11'h7FF);
    check_cw(11'h7FF, "ones");
  endtask

  task automatic t_walk;
    for (int k = 0; k < 11; k++) begin
      send(11'(1 << k));
      check_cw(11'(1 << k), "walk");
    end
  endtask

  task automatic t_stream;
    logic [10:0] lf = 11'h5A3;
    logic [10:0] prev;
    @(negedge clk_i);
    valid_i = 1'b1; d16 = lf; d8 = lf[4:0]; prev = lf;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[9:0], lf[10] ^ lf[8]};
      @(negedge clk_i);
      chk(vo16 && vo8, "R9 strobe", {14'b0, vo16, vo8}, 16'h3);
      check_cw(prev, "R9 stream");
      d16 = lf; d8 = lf[4:0]; prev = lf;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check_cw(prev, "R9 last");
  endtask

  task automatic t_hold;
    logic [15:0] h16;
    logic [7:0]  h8;
    send(11'h2C9);
    h16 = cw16; h8 = cw8;
    for (int i = 0; i < 4; i++) begin
      d16 = 11'(i * 11'h1F3 + 11'h155); d8 = d16[4:0];
      @(negedge clk_i);
      chk(!vo16 && !vo8, "R2 idle", {14'b0, vo16, vo8}, 16'h0);
      chk(cw16 == h16 && cw8 == h8, "R6 hold", cw16, h16);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    t_ones();
    t_walk();
    t_stream();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule